// File: doc/BRIEF.md
# Memory-device test access port with sample-and-float

This block is the boundary-test port of a memory device. A standard 16-state controller advances on TCK under TMS and selects one of three data registers through a 3-bit instruction: a 1-bit bypass stage, a 32-bit identification word, or a 109-stage boundary chain. The first 108 stages of the chain capture the device pins in parallel. The last stage is a control cell that can be reached only by scanning.

The port has no dedicated test reset. The power-on reset `por_n` puts it in Test-Logic-Reset, and the five-ones TMS sequence reaches the same state. Toward the device's data outputs the block produces a float request, a drive-override enable and the override data. The device's own output stage combines these. The sample-and-float instruction samples the pins and floats the outputs. The external-test instruction floats the outputs unless the control cell is set. When the cell is set, it drives the outputs with data preloaded by an earlier scan. Shift data leaves on TDO, which changes on the falling edge of TCK and carries a separate enable.

Top module: `memtap_top`

## Requirements
- R1: The controller implements the 16 standard states and TMS transitions on the rising TCK edge. Five consecutive TMS-high edges from any state reach Test-Logic-Reset. `por_n` low forces Test-Logic-Reset asynchronously.
- R2: In Test-Logic-Reset the instruction becomes IDCODE (001) and the control cell clears to 0. With IDCODE active, `out_hiz` and `out_drv_en` are both 0.
- R3: Capture-IR loads 001 into the instruction shift stage. Shift-IR shifts it toward TDO least significant bit first, with TDI entering bit 2. Update-IR installs the shifted code.
- R4: The instruction codes are 000 external test, 001 IDCODE, 010 sample-and-float, 100 sample and 111 BYPASS. The reserved codes 011, 101 and 110 select the 1-bit bypass stage.
- R5: The identification word is {revision[31:29], config[28:12], manufacturer[11:1], 1'b1}. Config holds density 010 in [16:14] and width 11 for x36 or 10 for x18 in [13:12]. It also holds DLL present=1 in [11], quad type=1 in [10], burst-of-four=0 in [9] and separate I/O=1 in [8], with [7:0] zero.
- R6: The bypass stage captures 0 in Capture-DR. Each Shift-DR edge loads TDI into it, so TDO lags TDI by one bit. It holds the last shifted bit after Shift-DR is left.
- R7: Under external test, sample and sample-and-float, Capture-DR loads `pin_in` into chain bits [107:0] and the control cell into bit 108. Shift-DR moves the chain toward bit 0, which drives TDO, with TDI entering bit 108.
- R8: Sample-and-float holds `out_hiz`=1 and `out_drv_en`=0 while active. Sample holds both at 0.
- R9: External test with the control cell at 0 gives `out_hiz`=1 and `out_drv_en`=0. With the cell at 1 it gives `out_hiz`=0 and `out_drv_en`=1.
- R10: Update-DR under sample or external test copies chain bits [35:0] into a preload register. Update-IR copies the preload register to `out_drv_data` only when the installed code is external test. No other event changes `out_drv_data`.
- R11: The control cell takes chain bit 108 at Update-DR only under sample or external test. Under any other instruction, Update-DR leaves it unchanged.
- R12: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. `tdo` and `tdo_oe` change on the falling edge of TCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test serial data in |
| tdo | output | 1 | Test serial data out, falling-edge timed |
| tdo_oe | output | 1 | TDO drive enable |
| pin_in | input | 108 | Parallel pin samples for the boundary chain |
| out_hiz | output | 1 | Request to float the device data outputs |
| out_drv_en | output | 1 | Request to drive the outputs from the override data |
| out_drv_data | output | 36 | Override data for the device data outputs |

## Verification
A bypass scan with an irregular bit pattern separates a one-bit delay from a pass-through or a longer path. Each reserved code is scanned the same way to show that it falls back to bypass. Full-length chain scans check several things at once:
- a fixed pin pattern shows that capture reaches every pin cell;
- the read-back of bit 108 shows whether the control cell was written;
- preload patterns that differ between consecutive scans show that the override data moves only at Update-IR of external test.

The control-cell sequences set the cell under sample, try to set it under sample-and-float, and clear it through Test-Logic-Reset. Each sequence ends by loading external test and observing float versus drive.

// File: rtl/memtap_pkg.sv
package memtap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_CHAIN
    } dr_sel_t;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] IR_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] IR_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] IR_SAMPZ   = 3'b010;
    localparam logic [IR_W-1:0] IR_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] IR_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
    import memtap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir
);

    tap_state_t state_q;
    tap_state_t state_d;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State decode: one strobe per action state, valid for the next rising edge
    always_comb begin
        in_reset = (state_q == ST_RESET);
        cap_dr   = (state_q == ST_CAP_DR);
        sh_dr    = (state_q == ST_SH_DR);
        upd_dr   = (state_q == ST_UPD_DR);
        cap_ir   = (state_q == ST_CAP_IR);
        sh_ir    = (state_q == ST_SH_IR);
        upd_ir   = (state_q == ST_UPD_IR);
    end

    assign state = state_q;

endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
    import memtap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb,
    output logic            load_extest,
    output dr_sel_t         dr_sel,
    output logic            is_extest,
    output logic            is_sampz,
    output logic            cell_wr_ok
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_r;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_sh <= IR_CAPTURE;
        end else if (cap_ir) begin
            ir_sh <= IR_CAPTURE;
        end else if (sh_ir) begin
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_r <= IR_IDCODE;
        end else if (in_reset) begin
            ir_r <= IR_IDCODE;
        end else if (upd_ir) begin
            ir_r <= ir_sh;
        end
    end

    always_comb begin
        dr_sel     = DR_BYPASS;
        is_extest  = 1'b0;
        is_sampz   = 1'b0;
        cell_wr_ok = 1'b0;
        unique case (ir_r)
            IR_EXTEST: begin
                dr_sel     = DR_CHAIN;
                is_extest  = 1'b1;
                cell_wr_ok = 1'b1;
            end
            IR_IDCODE: dr_sel = DR_IDENT;
            IR_SAMPZ: begin
                dr_sel   = DR_CHAIN;
                is_sampz = 1'b1;
            end
            IR_SAMPLE: begin
                dr_sel     = DR_CHAIN;
                cell_wr_ok = 1'b1;
            end
            default: dr_sel = DR_BYPASS;
        endcase
    end

    assign ir_q        = ir_r;
    assign ir_lsb      = ir_sh[0];
    assign load_extest = upd_ir && (ir_sh == IR_EXTEST);

endmodule

// File: rtl/memtap_idbyp.sv
module memtap_idbyp
    import memtap_pkg::*;
#(
    parameter logic [10:0] MFR_CODE = 11'h0D5,
    parameter logic [2:0]  REV_CODE = 3'b000,
    parameter bit          WIDE     = 1'b1
) (
    input  logic    tck,
    input  logic    por_n,
    input  logic    tdi,
    input  logic    cap_dr,
    input  logic    sh_dr,
    input  dr_sel_t dr_sel,
    output logic    id_lsb,
    output logic    byp_q
);

    localparam int          ID_W     = 32;
    localparam logic [1:0]  WIDTH_CD = WIDE ? 2'b11 : 2'b10;
    localparam logic [16:0] CFG      = {3'b010, WIDTH_CD, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00};
    localparam logic [ID_W-1:0] ID_VAL = {REV_CODE, CFG, MFR_CODE, 1'b1};

    logic [ID_W-1:0] id_sh;
    logic            byp_r;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            id_sh <= ID_VAL;
        end else if (dr_sel == DR_IDENT) begin
            if (cap_dr) begin
                id_sh <= ID_VAL;
            end else if (sh_dr) begin
                id_sh <= {tdi, id_sh[ID_W-1:1]};
            end
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            byp_r <= 1'b0;
        end else if (dr_sel == DR_BYPASS) begin
            if (cap_dr) begin
                byp_r <= 1'b0;
            end else if (sh_dr) begin
                byp_r <= tdi;
            end
        end
    end

    assign id_lsb = id_sh[0];
    assign byp_q  = byp_r;

endmodule

// File: rtl/memtap_chain.sv
module memtap_chain
    import memtap_pkg::*;
#(
    parameter int PIN_CNT = 108,
    parameter int OUT_CNT = 36
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  logic               in_reset,
    input  logic               cap_dr,
    input  logic               sh_dr,
    input  logic               upd_dr,
    input  logic               load_extest,
    input  dr_sel_t            dr_sel,
    input  logic               cell_wr_ok,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic               chain_lsb,
    output logic               ctl_cell,
    output logic [OUT_CNT-1:0] drive_q
);

    localparam int LEN = PIN_CNT + 1;
    localparam int CTL = PIN_CNT;

    logic [LEN-1:0]     chain;
    logic [LEN-1:0]     chain_d;
    logic               cap_en;
    logic               sh_en;
    logic               ctl_r;
    logic [OUT_CNT-1:0] preload;
    logic [OUT_CNT-1:0] drive_r;

    assign cap_en = cap_dr && (dr_sel == DR_CHAIN);
    assign sh_en  = sh_dr  && (dr_sel == DR_CHAIN);

    // Pin cells: capture a pin or take the neighbour above
    for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin_cell
        assign chain_d[i] = cap_en ? pin_in[i] : chain[i+1];
    end

    // Control cell at the top of the chain: captures its own state, shifts in TDI
    assign chain_d[CTL] = cap_en ? ctl_r : tdi;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            chain <= '0;
        end else if (cap_en || sh_en) begin
            chain <= chain_d;
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ctl_r   <= 1'b0;
            preload <= '0;
        end else if (in_reset) begin
            ctl_r   <= 1'b0;
        end else if (upd_dr && cell_wr_ok) begin
            ctl_r   <= chain[CTL];
            preload <= chain[OUT_CNT-1:0];
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            drive_r <= '0;
        end else if (load_extest) begin
            drive_r <= preload;
        end
    end

    assign chain_lsb = chain[0];
    assign ctl_cell  = ctl_r;
    assign drive_q   = drive_r;

endmodule

// File: rtl/memtap_top.sv
module memtap_top
    import memtap_pkg::*;
#(
    parameter int          PIN_CNT  = 108,
    parameter int          OUT_CNT  = 36,
    parameter logic [10:0] MFR_CODE = 11'h0D5,
    parameter logic [2:0]  REV_CODE = 3'b000,
    parameter bit          WIDE     = 1'b1
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic               out_hiz,
    output logic               out_drv_en,
    output logic [OUT_CNT-1:0] out_drv_data
);

    tap_state_t      state;
    logic            in_reset;
    logic            cap_dr;
    logic            sh_dr;
    logic            upd_dr;
    logic            cap_ir;
    logic            sh_ir;
    logic            upd_ir;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic            load_extest;
    dr_sel_t         dr_sel;
    logic            is_extest;
    logic            is_sampz;
    logic            cell_wr_ok;
    logic            id_lsb;
    logic            byp_q;
    logic            chain_lsb;
    logic            ctl_cell;
    logic            tdo_mux;
    logic            tdo_r;
    logic            oe_r;

    memtap_fsm u_fsm (
        .tck      (tck),
        .por_n    (por_n),
        .tms      (tms),
        .state    (state),
        .in_reset (in_reset),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .upd_dr   (upd_dr),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir)
    );

    memtap_ir u_ir (
        .tck         (tck),
        .por_n       (por_n),
        .tdi         (tdi),
        .in_reset    (in_reset),
        .cap_ir      (cap_ir),
        .sh_ir       (sh_ir),
        .upd_ir      (upd_ir),
        .ir_q        (ir_q),
        .ir_lsb      (ir_lsb),
        .load_extest (load_extest),
        .dr_sel      (dr_sel),
        .is_extest   (is_extest),
        .is_sampz    (is_sampz),
        .cell_wr_ok  (cell_wr_ok)
    );

    memtap_idbyp #(
        .MFR_CODE (MFR_CODE),
        .REV_CODE (REV_CODE),
        .WIDE     (WIDE)
    ) u_idbyp (
        .tck    (tck),
        .por_n  (por_n),
        .tdi    (tdi),
        .cap_dr (cap_dr),
        .sh_dr  (sh_dr),
        .dr_sel (dr_sel),
        .id_lsb (id_lsb),
        .byp_q  (byp_q)
    );

    memtap_chain #(
        .PIN_CNT (PIN_CNT),
        .OUT_CNT (OUT_CNT)
    ) u_chain (
        .tck         (tck),
        .por_n       (por_n),
        .tdi         (tdi),
        .in_reset    (in_reset),
        .cap_dr      (cap_dr),
        .sh_dr       (sh_dr),
        .upd_dr      (upd_dr),
        .load_extest (load_extest),
        .dr_sel      (dr_sel),
        .cell_wr_ok  (cell_wr_ok),
        .pin_in      (pin_in),
        .chain_lsb   (chain_lsb),
        .ctl_cell    (ctl_cell),
        .drive_q     (out_drv_data)
    );

    always_comb begin
        if (sh_ir) begin
            tdo_mux = ir_lsb;
        end else begin
            unique case (dr_sel)
                DR_IDENT: tdo_mux = id_lsb;
                DR_CHAIN: tdo_mux = chain_lsb;
                default:  tdo_mux = byp_q;
            endcase
        end
    end

    // Serial output stage retimed to the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo_r <= 1'b0;
            oe_r  <= 1'b0;
        end else begin
            tdo_r <= tdo_mux;
            oe_r  <= sh_ir || sh_dr;
        end
    end

    assign tdo        = tdo_r;
    assign tdo_oe     = oe_r;
    assign out_hiz    = is_sampz || (is_extest && !ctl_cell);
    assign out_drv_en = is_extest && ctl_cell;

endmodule

// File: rtl/memtap_chk.sv
module memtap_chk
    import memtap_pkg::*;
#(
    parameter int OUT_CNT = 36
) (
    input logic               tck,
    input logic               por_n,
    input logic               tms,
    input tap_state_t         state,
    input logic [IR_W-1:0]    ir_q,
    input logic               ctl_cell,
    input logic               tdo_oe,
    input logic               out_hiz,
    input logic               out_drv_en,
    input logic [OUT_CNT-1:0] out_drv_data
);

    assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!por_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_RESET));

    assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET) |=> (ir_q == IR_IDCODE && !ctl_cell));

    assert_sampz_float_R8: assert property (@(posedge tck) disable iff (!por_n)
        (ir_q == IR_SAMPZ) |-> (out_hiz && !out_drv_en));

    assert_extest_drive_R9: assert property (@(posedge tck) disable iff (!por_n)
        (ir_q == IR_EXTEST && ctl_cell) |-> (out_drv_en && !out_hiz));

    assert_drive_hold_R10: assert property (@(posedge tck) disable iff (!por_n)
        (state != ST_UPD_IR) |=> $stable(out_drv_data));

    assert_cell_guard_R11: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(ctl_cell) |->
            (($past(state) == ST_UPD_DR &&
              ($past(ir_q) == IR_SAMPLE || $past(ir_q) == IR_EXTEST)) ||
             $past(state) == ST_RESET));

    assert_oe_shift_only_R12: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind memtap_top memtap_chk #(.OUT_CNT(OUT_CNT)) u_chk (
    .tck          (tck),
    .por_n        (por_n),
    .tms          (tms),
    .state        (state),
    .ir_q         (ir_q),
    .ctl_cell     (ctl_cell),
    .tdo_oe       (tdo_oe),
    .out_hiz      (out_hiz),
    .out_drv_en   (out_drv_en),
    .out_drv_data (out_drv_data)
);

// File: tb/memtap_top_tb.sv
module memtap_top_tb;

    localparam int PIN_CNT = 108;
    localparam int OUT_CNT = 36;

    logic               tck = 1'b0;
    logic               por_n = 1'b0;
    logic               tms = 1'b1;
    logic               tdi = 1'b0;
    logic               tdo;
    logic               tdo_oe;
    logic [PIN_CNT-1:0] pin_in;
    logic               out_hiz;
    logic               out_drv_en;
    logic [OUT_CNT-1:0] out_drv_data;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] EXP_ID = {3'b000, 3'b010, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00,
                                      11'h0D5, 1'b1};

    memtap_top u_dut (
        .tck          (tck),
        .por_n        (por_n),
        .tms          (tms),
        .tdi          (tdi),
        .tdo          (tdo),
        .tdo_oe       (tdo_oe),
        .pin_in       (pin_in),
        .out_hiz      (out_hiz),
        .out_drv_en   (out_drv_en),
        .out_drv_data (out_drv_data)
    );

    always #5 tck = ~tck;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic t_ms, input logic t_di, output logic o_do,
                        output logic o_oe);
        @(negedge tck);
        #1;
        o_do = tdo;
        o_oe = tdo_oe;
        tms  = t_ms;
        tdi  = t_di;
        @(posedge tck);
        #1;
    endtask

    task automatic step_n(input logic t_ms);
        logic d, o;
        step(t_ms, 1'b0, d, o);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        logic b, o;
        step_n(1'b1); step_n(1'b1); step_n(1'b0); step_n(1'b0);
        for (int k = 0; k < 3; k++) begin
            step(k == 2, code[k], b, o);
            cap[k] = b;
        end
        step_n(1'b1); step_n(1'b0);
    endtask

    task automatic scan_dr(input logic [127:0] din, input int n,
                           output logic [127:0] dout, output logic all_oe);
        logic b, o;
        dout   = '0;
        all_oe = 1'b1;
        step_n(1'b1); step_n(1'b0); step_n(1'b0);
        for (int k = 0; k < n; k++) begin
            step(k == n - 1, din[k], b, o);
            dout[k] = b;
            all_oe  = all_oe & o;
        end
        step_n(1'b1); step_n(1'b0);
    endtask

    task automatic t_reset;
        logic [127:0] q;
        logic oe;
        chk(out_hiz == 1'b0 && out_drv_en == 1'b0, "R2 reset outputs",
            {out_hiz, out_drv_en}, 0);
        chk(tdo_oe == 1'b0, "R12 oe at reset", tdo_oe, 0);
        step_n(1'b0);
        scan_dr('0, 32, q, oe);
        chk(q[31:0] == EXP_ID, "R5 R2 idcode after reset", q[31:0], EXP_ID);
    endtask

    task automatic t_ir_capture;
        logic [2:0] c;
        load_ir(3'b111, c);
        chk(c == 3'b001, "R3 capture-IR pattern", c, 3'b001);
    endtask

    task automatic t_bypass;
        logic [127:0] q;
        logic oe;
        logic [7:0] din = 8'b1011_0010;
        scan_dr({120'h0, din}, 8, q, oe);
        chk(q[7:0] == {din[6:0], 1'b0}, "R6 bypass delay", q[7:0], {din[6:0], 1'b0});
        chk(oe == 1'b1, "R12 oe during shift", oe, 1);
        chk(tdo_oe == 1'b0, "R12 oe idle", tdo_oe, 0);
    endtask

    task automatic t_reserved;
        logic [127:0] q;
        logic oe;
        logic [2:0] c;
        logic [2:0] codes [3] = '{3'b011, 3'b101, 3'b110};
        logic [7:0] din = 8'b0110_1101;
        for (int i = 0; i < 3; i++) begin
            load_ir(codes[i], c);
            scan_dr({120'h0, din}, 8, q, oe);
            chk(q[7:0] == {din[6:0], 1'b0}, "R4 reserved code acts as bypass",
                q[7:0], {din[6:0], 1'b0});
        end
    endtask

    task automatic t_tdo_edge;
        logic d, o;
        load_ir(3'b111, d);
        step_n(1'b1); step_n(1'b0); step_n(1'b0);
        chk(tdo_oe == 1'b0, "R12 oe waits for falling edge", tdo_oe, 0);
        @(negedge tck);
        #1;
        chk(tdo_oe == 1'b1, "R12 oe after falling edge", tdo_oe, 1);
        step(1'b1, 1'b0, d, o);
        step_n(1'b1); step_n(1'b0);
    endtask

    task automatic t_sample_preload;
        logic [127:0] q;
        logic oe;
        logic [2:0] c;
        logic [127:0] din;
        load_ir(3'b100, c);
        chk(out_hiz == 1'b0 && out_drv_en == 1'b0, "R8 sample leaves outputs",
            {out_hiz, out_drv_en}, 0);
        din = {19'h0, 1'b1, 72'h0, 36'h123456789};
        scan_dr(din, 109, q, oe);
        chk(q[108:0] == {1'b0, pin_in}, "R7 sample capture", q[108:0], {1'b0, pin_in});
        chk(out_hiz == 1'b0 && out_drv_en == 1'b0, "R8 sample after update",
            {out_hiz, out_drv_en}, 0);
    endtask

    task automatic t_extest;
        logic [127:0] q;
        logic oe;
        logic [2:0] c;
        load_ir(3'b000, c);
        chk(out_drv_en == 1'b1 && out_hiz == 1'b0, "R9 extest drives with cell set",
            {out_hiz, out_drv_en}, 1);
        chk(out_drv_data == 36'h123456789, "R10 drive from preload",
            out_drv_data, 36'h123456789);
        pin_in = ~pin_in;
        scan_dr({19'h0, 1'b1, 72'h0, 36'hFEDCBA987}, 109, q, oe);
        chk(q[108:0] == {1'b1, pin_in}, "R11 R7 cell read-back and capture",
            q[108:0], {1'b1, pin_in});
        chk(out_drv_data == 36'h123456789, "R10 drive held until Update-IR",
            out_drv_data, 36'h123456789);
        load_ir(3'b000, c);
        chk(out_drv_data == 36'hFEDCBA987, "R10 drive reloaded", out_drv_data,
            36'hFEDCBA987);
        scan_dr({19'h0, 1'b0, 72'h0, 36'h0AAAA5555}, 109, q, oe);
        chk(out_hiz == 1'b1 && out_drv_en == 1'b0, "R9 extest floats with cell clear",
            {out_hiz, out_drv_en}, 2);
    endtask

    task automatic t_sampz;
        logic [127:0] q;
        logic oe;
        logic [2:0] c;
        load_ir(3'b010, c);
        chk(out_hiz == 1'b1 && out_drv_en == 1'b0, "R8 sample-and-float floats",
            {out_hiz, out_drv_en}, 2);
        scan_dr({19'h0, 1'b1, 72'h0, 36'h777777777}, 109, q, oe);
        chk(q[108:0] == {1'b0, pin_in}, "R7 sample-and-float capture", q[108:0],
            {1'b0, pin_in});
        load_ir(3'b000, c);
        chk(out_hiz == 1'b1 && out_drv_en == 1'b0, "R11 cell unchanged under sample-and-float",
            {out_hiz, out_drv_en}, 2);
        chk(out_drv_data == 36'h0AAAA5555, "R10 preload untouched by sample-and-float",
            out_drv_data, 36'h0AAAA5555);
    endtask

    task automatic t_logic_reset;
        logic [127:0] q;
        logic oe;
        logic [2:0] c;
        load_ir(3'b100, c);
        scan_dr({19'h0, 1'b1, 108'h0}, 109, q, oe);
        for (int i = 0; i < 5; i++) step_n(1'b1);
        step_n(1'b0);
        chk(out_hiz == 1'b0 && out_drv_en == 1'b0, "R2 IDCODE after reset state",
            {out_hiz, out_drv_en}, 0);
        load_ir(3'b000, c);
        chk(out_hiz == 1'b1 && out_drv_en == 1'b0, "R2 cell cleared by reset state",
            {out_hiz, out_drv_en}, 2);
        // Enter Shift-DR, then escape with five TMS-high edges
        step_n(1'b1); step_n(1'b0); step_n(1'b0);
        for (int i = 0; i < 5; i++) step_n(1'b1);
        step_n(1'b0);
        scan_dr('0, 32, q, oe);
        chk(q[31:0] == EXP_ID, "R1 five ones from Shift-DR", q[31:0], EXP_ID);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pin_in = {3{36'h93C5AE1F7}};
        repeat (3) @(posedge tck);
        #1;
        por_n = 1'b1;
        t_reset();
        t_ir_capture();
        t_bypass();
        t_reserved();
        t_tdo_edge();
        t_sample_preload();
        t_extest();
        t_sampz();
        t_logic_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule